// File: doc/BRIEF.md
# Asynchronous Registered I/O Macrocell

This block is one input/output cell of a programmable logic array meant for clockless and multi-clock designs. The array's AND plane sits outside the cell: the cell receives product terms that have already been evaluated. It splits the terms it owns into two OR groups and takes the XOR of the two sums as the data input of a state register. A second register samples the pin through its receiver. Each register has its own clock, set and reset, and each of these comes from a separate product-term input. When set and reset are raised together, the register's output follows its data input directly, with no clock.

A per-cell setting picks the output enable. It can come from a shared chip-level enable or from a local product term. A second setting picks the output polarity. A third picks which register feeds back into the array. While the pad driver is off, the pin works as an input for the cell. The number of product terms the cell owns depends on its position in a row of twelve cells. Slots above that count are ignored.

Top module: `mc_async_iocell`

## Requirements
- R1: With set and reset both low, a rising edge of the state clock term loads D = (OR of the lower group of owned terms) XOR (OR of the upper group). With the default 12 owned terms the lower group is `sop_pt_i[5:0]` and the upper group is `sop_pt_i[11:6]`. Changing the terms without a clock edge leaves the register output unchanged.
- R2: Product-term slots at or above the owned count have no effect on D. With the default settings these are `sop_pt_i[15:12]`.
- R3: With set and reset both low, a rising edge of the pin clock term loads the pin register from `pad_i`. `pad_i` carries the pin level: the outside level while the driver is off, and the driven level while it is on.
- R4: Set alone forces a register output to 1 at once and reset alone forces it to 0, with no clock. While either one is held alone, clock edges do not change the output.
- R5: With set and reset of a register both high, that register's output equals its data input continuously: the XOR of sums for the state register and `pad_i` for the pin register.
- R6: When a register leaves the bypass by dropping one control while the other stays high, its output takes the level of the control that stays high (1 for set, 0 for reset).
- R7: The pad enable `pad_oe_o` follows `glb_oe_i` when `cfg_oe_glb_i`=1 and follows `oe_pt_i` when `cfg_oe_glb_i`=0.
- R8: `pad_o` equals the state register output when `cfg_inv_i`=0 and its complement when `cfg_inv_i`=1.
- R9: `fb_o` carries the state register output when `cfg_fb_sel_i`=0 and the pin register output when `cfg_fb_sel_i`=1.
- R10: While `rst_n` is low both registers read 0 and `pad_oe_o` is 0, whatever the other inputs do.
- R11: A cell at position k (0..11) owns 4, 12, 6, 10, 8, 8, 8, 8, 10, 6, 12, 4 terms for k = 0..11 in that order. Its lower group is the first half of the owned terms. For position 0 the groups are bits [1:0] and [3:2], and bit 4 and above have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low simulation reset; clears both registers and disables the pad |
| sop_pt_i | input | PT_SLOTS | Evaluated product terms offered to the cell |
| st_clk_pt_i | input | 1 | State register clock term (rising edge) |
| st_set_pt_i | input | 1 | State register set term |
| st_rst_pt_i | input | 1 | State register reset term |
| pin_clk_pt_i | input | 1 | Pin register clock term (rising edge) |
| pin_set_pt_i | input | 1 | Pin register set term |
| pin_rst_pt_i | input | 1 | Pin register reset term |
| oe_pt_i | input | 1 | Local output-enable term |
| glb_oe_i | input | 1 | Shared chip-level output enable |
| cfg_oe_glb_i | input | 1 | 1: use the shared enable, 0: use the local term |
| cfg_inv_i | input | 1 | 1: drive the complement of the state register |
| cfg_fb_sel_i | input | 1 | 1: feed back the pin register, 0: the state register |
| pad_i | input | 1 | Pin receiver level |
| pad_o | output | 1 | Pad driver data |
| pad_oe_o | output | 1 | Pad driver enable; pin is high-impedance when 0 |
| fb_o | output | 1 | Feedback into the array |

## Verification
The assertions sample on each edge of the two product-term clocks. At each such edge they check the continuous rules. A forced set or reset must show its level. A bypassed register must equal its data input. The feedback must come from the selected register. Reset must keep the pad off and the state register clear. The data loaded on an edge, the effect of ignored term slots, the exit from bypass into a single control, the enable and polarity choices, and the term split of another cell position are shown only by the bench's scenarios. These depend on sequences of stimulus or on a second parameter setting.

// File: rtl/mc_cell_pkg.sv
package mc_cell_pkg;

  localparam int MASK_W = 64;

  typedef enum logic {
    FB_FROM_STATE   = 1'b0,
    FB_FROM_PIN_REG = 1'b1
  } fb_src_e;

  // Term count for the first four positions; the row is mirrored end to end
  // and the middle four positions own eight terms each.
  function automatic int edge_term_count(input int pos);
    if ((pos % 2) == 0) return 4 + pos;
    return 13 - pos;
  endfunction

  function automatic int cell_term_count(input int pos);
    if (pos < 4)  return edge_term_count(pos);
    if (pos < 8)  return 8;
    return edge_term_count(11 - pos);
  endfunction

  // Mask with ones on bits [lo, lo+n).
  function automatic logic [MASK_W-1:0] group_mask(input int lo, input int n);
    logic [MASK_W-1:0] m;
    m = '0;
    for (int i = 0; i < MASK_W; i++) begin
      if (i >= lo && i < lo + n) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/mc_sop_xor.sv
module mc_sop_xor
  import mc_cell_pkg::*;
#(
  parameter int PT_SLOTS = 16,
  parameter int TERMS    = 12
) (
  input  logic [PT_SLOTS-1:0] pt_i,
  output logic                sum_lo_o,
  output logic                sum_hi_o,
  output logic                d_o
);
  localparam int LO_N = TERMS / 2;
  localparam int HI_N = TERMS - LO_N;
  localparam logic [MASK_W-1:0] LO_MASK = group_mask(0, LO_N);
  localparam logic [MASK_W-1:0] HI_MASK = group_mask(LO_N, HI_N);

  assign sum_lo_o = |(pt_i & LO_MASK[PT_SLOTS-1:0]);
  assign sum_hi_o = |(pt_i & HI_MASK[PT_SLOTS-1:0]);
  assign d_o      = sum_lo_o ^ sum_hi_o;
endmodule

// File: rtl/mc_bypass_reg.sv
module mc_bypass_reg (
  input  logic rst_n,
  input  logic clk_pt,
  input  logic set_pt,
  input  logic rst_pt,
  input  logic d_i,
  output logic bypass_o,
  output logic q_o
);
  logic set_only;
  logic clr_only;
  logic q_reg;

  // Each async control is live only when asserted alone, so releasing one
  // of a held pair yields an edge on the other.
  assign set_only = set_pt & ~rst_pt & rst_n;
  assign clr_only = (rst_pt & ~set_pt) | ~rst_n;
  assign bypass_o = set_pt & rst_pt & rst_n;

  always_ff @(posedge clk_pt or posedge set_only or posedge clr_only) begin
    if (clr_only)      q_reg <= 1'b0;
    else if (set_only) q_reg <= 1'b1;
    else               q_reg <= d_i;
  end

  assign q_o = bypass_o ? d_i : q_reg;
endmodule

// File: rtl/mc_pad_ctl.sv
module mc_pad_ctl (
  input  logic rst_n,
  input  logic cfg_oe_glb,
  input  logic glb_oe,
  input  logic loc_oe,
  input  logic cfg_inv,
  input  logic data_i,
  output logic oe_sel_o,
  output logic pad_o,
  output logic pad_oe_o
);
  assign oe_sel_o = cfg_oe_glb ? glb_oe : loc_oe;
  assign pad_oe_o = oe_sel_o & rst_n;
  assign pad_o    = data_i ^ cfg_inv;
endmodule

// File: rtl/mc_async_iocell.sv
module mc_async_iocell
  import mc_cell_pkg::*;
#(
  parameter int PT_SLOTS = 16,
  parameter int CELL_IDX = 1
) (
  input  logic                rst_n,
  input  logic [PT_SLOTS-1:0] sop_pt_i,
  input  logic                st_clk_pt_i,
  input  logic                st_set_pt_i,
  input  logic                st_rst_pt_i,
  input  logic                pin_clk_pt_i,
  input  logic                pin_set_pt_i,
  input  logic                pin_rst_pt_i,
  input  logic                oe_pt_i,
  input  logic                glb_oe_i,
  input  logic                cfg_oe_glb_i,
  input  logic                cfg_inv_i,
  input  logic                cfg_fb_sel_i,
  input  logic                pad_i,
  output logic                pad_o,
  output logic                pad_oe_o,
  output logic                fb_o
);
  localparam int TERMS = cell_term_count(CELL_IDX);

  logic    sum_lo, sum_hi, st_d;
  logic    st_q, st_bypass;
  logic    pin_q, pin_bypass;
  logic    oe_sel;
  fb_src_e fb_src;

  mc_sop_xor #(.PT_SLOTS(PT_SLOTS), .TERMS(TERMS)) i_sop (
    .pt_i     (sop_pt_i),
    .sum_lo_o (sum_lo),
    .sum_hi_o (sum_hi),
    .d_o      (st_d)
  );

  mc_bypass_reg i_state_reg (
    .rst_n    (rst_n),
    .clk_pt   (st_clk_pt_i),
    .set_pt   (st_set_pt_i),
    .rst_pt   (st_rst_pt_i),
    .d_i      (st_d),
    .bypass_o (st_bypass),
    .q_o      (st_q)
  );

  mc_bypass_reg i_pin_reg (
    .rst_n    (rst_n),
    .clk_pt   (pin_clk_pt_i),
    .set_pt   (pin_set_pt_i),
    .rst_pt   (pin_rst_pt_i),
    .d_i      (pad_i),
    .bypass_o (pin_bypass),
    .q_o      (pin_q)
  );

  mc_pad_ctl i_pad (
    .rst_n      (rst_n),
    .cfg_oe_glb (cfg_oe_glb_i),
    .glb_oe     (glb_oe_i),
    .loc_oe     (oe_pt_i),
    .cfg_inv    (cfg_inv_i),
    .data_i     (st_q),
    .oe_sel_o   (oe_sel),
    .pad_o      (pad_o),
    .pad_oe_o   (pad_oe_o)
  );

  assign fb_src = fb_src_e'(cfg_fb_sel_i);
  assign fb_o   = (fb_src == FB_FROM_PIN_REG) ? pin_q : st_q;
endmodule

// File: rtl/mc_async_iocell_chk.sv
module mc_async_iocell_chk (
  input logic rst_n,
  input logic st_clk,
  input logic st_set,
  input logic st_rst,
  input logic st_d,
  input logic st_q,
  input logic pin_clk,
  input logic pin_set,
  input logic pin_rst,
  input logic pad_i,
  input logic pin_q,
  input logic fb_sel,
  input logic fb_o,
  input logic pad_oe
);
  // R5
  st_bypass_follow_chk: assert property (@(posedge st_clk) disable iff (!rst_n)
    (st_set && st_rst) |-> (st_q == st_d));

  // R5
  pin_bypass_follow_chk: assert property (@(posedge pin_clk) disable iff (!rst_n)
    (pin_set && pin_rst) |-> (pin_q == pad_i));

  // R4
  st_set_force_chk: assert property (@(posedge st_clk) disable iff (!rst_n)
    (st_set && !st_rst) |-> st_q);

  // R4
  st_clr_force_chk: assert property (@(posedge st_clk) disable iff (!rst_n)
    (st_rst && !st_set) |-> !st_q);

  // R4
  pin_set_force_chk: assert property (@(posedge pin_clk) disable iff (!rst_n)
    (pin_set && !pin_rst) |-> pin_q);

  // R9
  fb_route_chk: assert property (@(posedge pin_clk) disable iff (!rst_n)
    fb_o == (fb_sel ? pin_q : st_q));

  // R10
  reset_quiet_chk: assert property (@(posedge st_clk)
    !rst_n |-> (!pad_oe && !st_q));
endmodule

bind mc_async_iocell mc_async_iocell_chk i_chk (
  .rst_n   (rst_n),
  .st_clk  (st_clk_pt_i),
  .st_set  (st_set_pt_i),
  .st_rst  (st_rst_pt_i),
  .st_d    (st_d),
  .st_q    (st_q),
  .pin_clk (pin_clk_pt_i),
  .pin_set (pin_set_pt_i),
  .pin_rst (pin_rst_pt_i),
  .pad_i   (pad_i),
  .pin_q   (pin_q),
  .fb_sel  (cfg_fb_sel_i),
  .fb_o    (fb_o),
  .pad_oe  (pad_oe_o)
);

// File: tb/test_mc_async_iocell.sv
module test_mc_async_iocell;
  localparam int SLOTS = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n = 1'b0;
  logic [SLOTS-1:0] pt = '0;
  logic st_clk = 0, st_set = 0, st_rst = 0;
  logic pn_clk = 0, pn_set = 0, pn_rst = 0;
  logic oe_pt = 0, glb_oe = 0, cfg_glb = 0, cfg_inv = 0, cfg_fb = 0;
  logic ext_pin = 0;
  logic pad_i, pad_o, pad_oe, fb_o;
  logic pad_i_c0, pad_o_c0, pad_oe_c0, fb_o_c0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Pin model: the receiver sees the driven level while the driver is on.
  assign pad_i    = pad_oe    ? pad_o    : ext_pin;
  assign pad_i_c0 = pad_oe_c0 ? pad_o_c0 : ext_pin;

  mc_async_iocell #(.PT_SLOTS(SLOTS), .CELL_IDX(1)) i_mc_async_iocell (
    .rst_n(rst_n), .sop_pt_i(pt),
    .st_clk_pt_i(st_clk), .st_set_pt_i(st_set), .st_rst_pt_i(st_rst),
    .pin_clk_pt_i(pn_clk), .pin_set_pt_i(pn_set), .pin_rst_pt_i(pn_rst),
    .oe_pt_i(oe_pt), .glb_oe_i(glb_oe), .cfg_oe_glb_i(cfg_glb),
    .cfg_inv_i(cfg_inv), .cfg_fb_sel_i(cfg_fb), .pad_i(pad_i),
    .pad_o(pad_o), .pad_oe_o(pad_oe), .fb_o(fb_o));

  mc_async_iocell #(.PT_SLOTS(SLOTS), .CELL_IDX(0)) i_mc_async_iocell_c0 (
    .rst_n(rst_n), .sop_pt_i(pt),
    .st_clk_pt_i(st_clk), .st_set_pt_i(st_set), .st_rst_pt_i(st_rst),
    .pin_clk_pt_i(pn_clk), .pin_set_pt_i(pn_set), .pin_rst_pt_i(pn_rst),
    .oe_pt_i(oe_pt), .glb_oe_i(glb_oe), .cfg_oe_glb_i(cfg_glb),
    .cfg_inv_i(cfg_inv), .cfg_fb_sel_i(cfg_fb), .pad_i(pad_i_c0),
    .pad_o(pad_o_c0), .pad_oe_o(pad_oe_c0), .fb_o(fb_o_c0));

  // Expected data input, restated from R1/R11 for a cell owning n terms.
  function automatic logic exp_d(input logic [SLOTS-1:0] p, input int n);
    logic lo, hi;
    lo = 0; hi = 0;
    for (int i = 0; i < n; i++) begin
      if (i < n / 2) lo = lo | p[i];
      else           hi = hi | p[i];
    end
    return lo ^ hi;
  endfunction

  task automatic check(input logic act, input logic exp, input string req, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic pulse_st();
    st_clk = 1; #1; st_clk = 0; settle();
  endtask

  task automatic pulse_pin();
    pn_clk = 1; #1; pn_clk = 0; settle();
  endtask

  task automatic t_reset();
    st_set = 1; oe_pt = 1; glb_oe = 1; settle();
    check(pad_oe, 1'b0, "R10", "pad enable in reset");
    check(fb_o, 1'b0, "R10", "state reg in reset");
    cfg_fb = 1; pn_set = 1; settle();
    check(fb_o, 1'b0, "R10", "pin reg in reset");
    st_set = 0; pn_set = 0; oe_pt = 0; glb_oe = 0; cfg_fb = 0; settle();
    rst_n = 1; settle();
    check(fb_o, 1'b0, "R10", "state reg after release");
  endtask

  task automatic t_sop();
    logic [SLOTS-1:0] pats [6] = '{16'h0001, 16'h0041, 16'h0800, 16'h0FFF, 16'h0C20, 16'h0003};
    cfg_fb = 0;
    foreach (pats[i]) begin
      pt = pats[i]; settle(); pulse_st();
      check(fb_o, exp_d(pats[i], 12), "R1", $sformatf("load pattern %h", pats[i]));
    end
    pt = 16'h0001; settle(); pulse_st();
    pt = 16'h0041; settle();
    check(fb_o, 1'b1, "R1", "no load without clock edge");
  endtask

  task automatic t_unused();
    pt = 16'hF000; settle(); pulse_st();
    check(fb_o, 1'b0, "R2", "only unowned slots set");
    pt = 16'hF020; settle(); pulse_st();
    check(fb_o, 1'b1, "R2", "unowned slots with lower group");
  endtask

  task automatic t_pin();
    cfg_glb = 0; oe_pt = 0; cfg_fb = 1;
    ext_pin = 1; settle(); pulse_pin();
    check(fb_o, 1'b1, "R3", "capture outside level 1");
    ext_pin = 0; settle();
    check(fb_o, 1'b1, "R3", "hold without edge");
    pulse_pin();
    check(fb_o, 1'b0, "R3", "capture outside level 0");
    pt = 16'h0001; settle(); pulse_st();
    oe_pt = 1; settle(); pulse_pin();
    check(fb_o, 1'b1, "R3", "capture driven level");
    oe_pt = 0; cfg_fb = 0; settle();
  endtask

  task automatic t_force();
    cfg_fb = 0; pt = 16'h0000; settle(); pulse_st();
    st_set = 1; settle();
    check(fb_o, 1'b1, "R4", "set alone forces 1");
    pulse_st();
    check(fb_o, 1'b1, "R4", "clock ignored under set");
    st_set = 0; st_rst = 1; pt = 16'h0001; settle();
    check(fb_o, 1'b0, "R4", "reset alone forces 0");
    pulse_st();
    check(fb_o, 1'b0, "R4", "clock ignored under reset");
    st_rst = 0; settle();
    cfg_fb = 1; ext_pin = 0; pn_set = 1; settle();
    check(fb_o, 1'b1, "R4", "pin reg set alone");
    pn_set = 0; pn_rst = 1; ext_pin = 1; settle(); pulse_pin();
    check(fb_o, 1'b0, "R4", "pin reg reset alone");
    pn_rst = 0; cfg_fb = 0; settle();
  endtask

  task automatic t_bypass();
    cfg_fb = 0; st_set = 1; st_rst = 1;
    pt = 16'h0001; settle();
    check(fb_o, 1'b1, "R5", "state bypass D=1");
    pt = 16'h0041; settle();
    check(fb_o, 1'b0, "R5", "state bypass D=0");
    pt = 16'h0040; settle();
    check(fb_o, 1'b1, "R5", "state bypass upper group");
    cfg_fb = 1; oe_pt = 0; pn_set = 1; pn_rst = 1;
    ext_pin = 1; settle();
    check(fb_o, 1'b1, "R5", "pin bypass 1");
    ext_pin = 0; settle();
    check(fb_o, 1'b0, "R5", "pin bypass 0");
    pn_set = 0; pn_rst = 0; cfg_fb = 0; settle();
  endtask

  task automatic t_release();
    pt = 16'h0000; settle();
    check(fb_o, 1'b0, "R6", "bypass shows D=0");
    st_rst = 0; settle();
    check(fb_o, 1'b1, "R6", "exit into set alone");
    st_rst = 1; pt = 16'h0001; settle();
    check(fb_o, 1'b1, "R6", "bypass shows D=1");
    st_set = 0; settle();
    check(fb_o, 1'b0, "R6", "exit into reset alone");
    st_rst = 0; settle();
  endtask

  task automatic t_oe();
    cfg_glb = 1; glb_oe = 1; oe_pt = 0; settle();
    check(pad_oe, 1'b1, "R7", "shared enable on");
    glb_oe = 0; oe_pt = 1; settle();
    check(pad_oe, 1'b0, "R7", "shared enable off, local on");
    cfg_glb = 0; settle();
    check(pad_oe, 1'b1, "R7", "local enable on");
    glb_oe = 1; oe_pt = 0; settle();
    check(pad_oe, 1'b0, "R7", "local off, shared on");
    glb_oe = 0; settle();
  endtask

  task automatic t_pol();
    pt = 16'h0001; settle(); pulse_st();
    cfg_inv = 0; settle();
    check(pad_o, 1'b1, "R8", "true polarity of 1");
    cfg_inv = 1; settle();
    check(pad_o, 1'b0, "R8", "inverted polarity of 1");
    pt = 16'h0000; settle(); pulse_st();
    check(pad_o, 1'b1, "R8", "inverted polarity of 0");
    cfg_inv = 0; settle();
  endtask

  task automatic t_fbsel();
    pt = 16'h0001; settle(); pulse_st();
    oe_pt = 0; ext_pin = 0; settle(); pulse_pin();
    cfg_fb = 0; settle();
    check(fb_o, 1'b1, "R9", "feedback from state reg");
    cfg_fb = 1; settle();
    check(fb_o, 1'b0, "R9", "feedback from pin reg");
    cfg_fb = 0; settle();
  endtask

  task automatic t_cell0();
    cfg_fb = 0;
    pt = 16'h0005; settle(); pulse_st();
    check(fb_o_c0, exp_d(16'h0005, 4), "R11", "position 0 groups [1:0]/[3:2]");
    check(fb_o, exp_d(16'h0005, 12), "R11", "position 1 same terms");
    pt = 16'h0010; settle(); pulse_st();
    check(fb_o_c0, 1'b0, "R11", "position 0 bit 4 unowned");
    pt = 16'h0004; settle(); pulse_st();
    check(fb_o_c0, 1'b1, "R11", "position 0 upper group");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    settle();
    t_reset();
    t_sop();
    t_unused();
    t_pin();
    t_force();
    t_bypass();
    t_release();
    t_oe();
    t_pol();
    t_fbsel();
    t_cell0();
    finish_run();
  end
endmodule